// File: doc/BRIEF.md
# Dual-Bank Endpoint Buffer Controller

This block keeps the bank bookkeeping for one device-side USB endpoint that uses two ping-pong buffers. It counts the banks that hold committed or received data, and it keeps two one-bit pointers: the bank that software works on and the bank that the packet engine uses next. It also presents a FIFO-control status bit and two event flags, each of which has its own interrupt enable. The data memory, the USB signalling and the register bus all live outside the block. Software actions reach it as single-cycle write-one pulses, and packet-engine events reach it as single-cycle pulses.

The endpoint direction is a static input, `dirIn`, which may change only while reset is held. On an IN endpoint, software fills a bank and commits it, and the engine later reports that the bank went out on the bus. Software can also withdraw the most recently committed IN bank with a kill procedure that runs for a fixed number of cycles. The block resolves the case where an IN token consumes that bank while the kill is pending. On an OUT endpoint, the engine reports filled banks, and software frees each bank after reading it.

Top module: `ep_bank_ctrl`

## Requirements
- R1: A synchronous active-high reset sets `busyCount` to 0, points `swBank` and `engBank` at bank 0, and clears `flags`, `enables`, `irq` and `killBusy`.
- R2: In IN mode (`dirIn`=1), when `swRelease` is pulsed with `busyCount` below 2, no kill running and no `swKillSet` in the same cycle, `busyCount` rises by one and `swBank` toggles at the next edge. In IN mode `fifoCtrl` is 1 whenever `busyCount` is below 2.
- R3: In IN mode, a `pktInSent` pulse with `busyCount` above 0 lowers the count by one, toggles `engBank` and sets the transmit flag `flags[0]` at the next edge. With a count of 0 the pulse changes nothing.
- R4: The count never leaves the range 0 to 2. An IN commit when the count is 2 is ignored, and so is an OUT reception when the count is 2: the count, the pointers and `flags[1]` stay as they were.
- R5: In OUT mode (`dirIn`=0), a `pktOutRcvd` pulse with the count below 2 raises the count, toggles `engBank` and sets the receive flag `flags[1]`. In OUT mode `fifoCtrl` is 1 whenever the count is above 0, so it rises at the same edge as `flags[1]`.
- R6: In OUT mode, a `swRelease` pulse with the count above 0 lowers the count by one and toggles `swBank`.
- R7: In IN mode, a `swKillSet` pulse that leaves at least one bank busy raises `killBusy` at the next edge. When no token arrives, `killBusy` stays high for exactly KILL_CYCLES cycles. It then falls, and at that same edge the count drops by one and `swBank` steps back to the withdrawn bank. `flags[0]` is not set.
- R8: With one bank busy, a `pktInSent` during the kill, or in the cycle of the kill request, sends the bank. The count goes to 0, `flags[0]` is set, `swBank` is unchanged, and `killBusy` is low after that edge.
- R9: With two banks busy and a kill running, a `pktInSent` sends the older bank and sets `flags[0]`. The newer bank is still discarded when the kill completes, which leaves the count at 0.
- R10: A `swKillSet` in OUT mode, or one that finds no bank busy, never raises `killBusy` and leaves the count unchanged. `pktInSent` has no effect in OUT mode and `pktOutRcvd` has no effect in IN mode.
- R11: In IN mode, `swRelease` is ignored while `killBusy` is high and in the cycle of a `swKillSet`.
- R12: Each bit of `flagClr` clears its flag at the next edge. A flag-setting event in the same cycle takes priority over the clear.
- R13: `enSet[i]` sets `enables[i]` and `enClr[i]` clears it, with set taking priority. `irq[i]` is 1 exactly when both `flags[i]` and `enables[i]` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dirIn | input | 1 | Endpoint direction: 1 IN, 0 OUT; changes only under reset |
| swRelease | input | 1 | Software FIFO-control clear strobe (commit or free) |
| swKillSet | input | 1 | Software request to withdraw the last committed IN bank |
| flagClr | input | 2 | Write-one clear per flag (bit 0 transmit, bit 1 receive) |
| enSet | input | 2 | Write-one set per interrupt enable |
| enClr | input | 2 | Write-one clear per interrupt enable |
| pktInSent | input | 1 | Packet engine sent an IN bank |
| pktOutRcvd | input | 1 | Packet engine filled an OUT bank |
| busyCount | output | 2 | Number of busy banks, 0 to 2 |
| swBank | output | 1 | Bank currently owned by software |
| engBank | output | 1 | Bank the packet engine uses next |
| fifoCtrl | output | 1 | FIFO-control status: bank free (IN) or bank full (OUT) |
| killBusy | output | 1 | Kill procedure in progress |
| flags | output | 2 | Event flags: bit 0 transmitted IN, bit 1 received OUT |
| enables | output | 2 | Interrupt enables |
| irq | output | 2 | Per-flag interrupt requests |

## Verification
Every piece of state is a register that drives a port directly or through one gate. A wrong count, a pointer that fails to toggle, or a lost flag therefore shows up at the first sample after the faulty edge. A kill timer that is off by one shows up as `killBusy` falling one cycle early or late, and the count drops at that wrong edge too. A mishandled race is visible when the count falls by two, or when `flags[0]` stays low after a send that happened during a kill.

// File: rtl/ep_bank_pkg.sv
package ep_bank_pkg;

  localparam int FLAG_NUM = 2;
  localparam int FLAG_TX  = 0;
  localparam int FLAG_RX  = 1;

  // Strobes from the control side to the bank datapath, one cycle each.
  typedef struct packed {
    logic                cntInc;     // a bank became busy
    logic                cntDecEng;  // engine consumed a bank
    logic                cntDecSw;   // software freed or kill discarded a bank
    logic                swStep;     // toggle software pointer
    logic                engStep;    // toggle engine pointer
    logic [FLAG_NUM-1:0] flagSet;    // event flags to raise
  } bankStrobe_t;

endpackage

// File: rtl/ep_bank_ctrl_fsm.sv
module ep_bank_ctrl_fsm
  import ep_bank_pkg::*;
#(
  parameter int KILL_CYCLES = 2,
  localparam int TIMER_W = $clog2(KILL_CYCLES + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        dirIn,
  input  logic        swRelease,
  input  logic        swKillSet,
  input  logic        pktInSent,
  input  logic        pktOutRcvd,
  input  logic [1:0]  busyCount,
  output bankStrobe_t strobe,
  output logic        killBusy
);

  logic [TIMER_W-1:0] killTimer;
  logic [1:0]         afterSend;
  logic               inSend, inCommit, inDiscard, killEnd, killStart;
  logic               outRecv, outFree;

  always_comb begin
    inSend    = dirIn && pktInSent && (busyCount != 2'd0);
    afterSend = busyCount - {1'b0, inSend};
    inCommit  = 1'b0;
    inDiscard = 1'b0;
    killEnd   = 1'b0;
    killStart = 1'b0;
    if (dirIn) begin
      if (killBusy) begin
        if (afterSend == 2'd0)                 killEnd   = 1'b1;  // token took the target
        else if (killTimer == TIMER_W'(1))     inDiscard = 1'b1;
      end else begin
        inCommit  = swRelease && !swKillSet && (busyCount != 2'd2);
        killStart = swKillSet && (afterSend != 2'd0);
      end
    end
    outRecv = !dirIn && pktOutRcvd && (busyCount != 2'd2);
    outFree = !dirIn && swRelease  && (busyCount != 2'd0);

    strobe.cntInc           = inCommit | outRecv;
    strobe.cntDecEng        = inSend;
    strobe.cntDecSw         = inDiscard | outFree;
    strobe.swStep           = inCommit | inDiscard | outFree;
    strobe.engStep          = inSend | outRecv;
    strobe.flagSet          = '0;
    strobe.flagSet[FLAG_TX] = inSend;
    strobe.flagSet[FLAG_RX] = outRecv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      killBusy  <= 1'b0;
      killTimer <= '0;
    end else if (killBusy) begin
      if (killEnd || inDiscard) killBusy <= 1'b0;
      else                      killTimer <= killTimer - TIMER_W'(1);
    end else if (killStart) begin
      killBusy  <= 1'b1;
      killTimer <= TIMER_W'(KILL_CYCLES);
    end
  end

  // Independent age counter for the kill window check.
  logic [TIMER_W-1:0] killAge;
  always_ff @(posedge clk) begin
    if (rst || !killBusy) killAge <= '0;
    else                  killAge <= killAge + TIMER_W'(1);
  end

  AST_KILL_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    killBusy |-> (int'(killAge) < KILL_CYCLES)); // R7

  AST_KILL_START: assert property (@(posedge clk) disable iff (rst)
    $rose(killBusy) |-> ($past(dirIn) && $past(busyCount) != 2'd0)); // R10

endmodule

// File: rtl/ep_bank_dp.sv
module ep_bank_dp
  import ep_bank_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  bankStrobe_t         strobe,
  input  logic [FLAG_NUM-1:0] flagClr,
  input  logic [FLAG_NUM-1:0] enSet,
  input  logic [FLAG_NUM-1:0] enClr,
  output logic [1:0]          busyCount,
  output logic                swBank,
  output logic                engBank,
  output logic [FLAG_NUM-1:0] flags,
  output logic [FLAG_NUM-1:0] enables,
  output logic [FLAG_NUM-1:0] irq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      busyCount <= 2'd0;
      swBank    <= 1'b0;
      engBank   <= 1'b0;
    end else begin
      busyCount <= busyCount + {1'b0, strobe.cntInc}
                 - {1'b0, strobe.cntDecEng} - {1'b0, strobe.cntDecSw};
      if (strobe.swStep)  swBank  <= ~swBank;
      if (strobe.engStep) engBank <= ~engBank;
    end
  end

  for (genvar i = 0; i < FLAG_NUM; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flags[i]   <= 1'b0;
        enables[i] <= 1'b0;
      end else begin
        flags[i]   <= strobe.flagSet[i] | (flags[i] & ~flagClr[i]);
        enables[i] <= enSet[i] | (enables[i] & ~enClr[i]);
      end
    end
    assign irq[i] = flags[i] & enables[i];

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
      $fell(flags[i]) |-> $past(flagClr[i])); // R12
    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst)
      $rose(flags[i]) |-> $past(strobe.flagSet[i])); // R12
    AST_EN_RISE: assert property (@(posedge clk) disable iff (rst)
      $rose(enables[i]) |-> $past(enSet[i])); // R13
  end

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    busyCount != 2'd3); // R4

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (busyCount == 2'd0 && !swBank && !engBank && flags == '0)); // R1

endmodule

// File: rtl/ep_bank_ctrl.sv
module ep_bank_ctrl
  import ep_bank_pkg::*;
#(
  parameter int KILL_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       dirIn,
  input  logic       swRelease,
  input  logic       swKillSet,
  input  logic [1:0] flagClr,
  input  logic [1:0] enSet,
  input  logic [1:0] enClr,
  input  logic       pktInSent,
  input  logic       pktOutRcvd,
  output logic [1:0] busyCount,
  output logic       swBank,
  output logic       engBank,
  output logic       fifoCtrl,
  output logic       killBusy,
  output logic [1:0] flags,
  output logic [1:0] enables,
  output logic [1:0] irq
);

  bankStrobe_t strobe;

  ep_bank_ctrl_fsm #(.KILL_CYCLES(KILL_CYCLES)) u_fsm (
    .clk(clk), .rst(rst), .dirIn(dirIn),
    .swRelease(swRelease), .swKillSet(swKillSet),
    .pktInSent(pktInSent), .pktOutRcvd(pktOutRcvd),
    .busyCount(busyCount), .strobe(strobe), .killBusy(killBusy)
  );

  ep_bank_dp u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .flagClr(flagClr), .enSet(enSet), .enClr(enClr),
    .busyCount(busyCount), .swBank(swBank), .engBank(engBank),
    .flags(flags), .enables(enables), .irq(irq)
  );

  // IN: current bank free to fill; OUT: current bank holds data.
  assign fifoCtrl = dirIn ? (busyCount != 2'd2) : (busyCount != 2'd0);

  AST_OUT_FIFO_RX: assert property (@(posedge clk) disable iff (rst)
    (!dirIn && $rose(fifoCtrl)) |-> flags[FLAG_RX]); // R5

  AST_COMMIT_FULL: assert property (@(posedge clk) disable iff (rst)
    (dirIn && swRelease && !swKillSet && !killBusy && !pktInSent && busyCount == 2'd2)
      |=> (busyCount == 2'd2 && $stable(swBank))); // R4

  AST_RACE_END: assert property (@(posedge clk) disable iff (rst)
    (dirIn && killBusy && pktInSent && busyCount == 2'd1)
      |=> (!killBusy && busyCount == 2'd0 && flags[FLAG_TX])); // R8

endmodule

// File: tb/ep_bank_ctrl_bench.sv
module ep_bank_ctrl_bench;

  localparam int KILL_CYCLES = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dirIn = 1'b1;
  logic swRelease = 0, swKillSet = 0, pktInSent = 0, pktOutRcvd = 0;
  logic [1:0] flagClr = 0, enSet = 0, enClr = 0;
  logic [1:0] busyCount, flags, enables, irq;
  logic swBank, engBank, fifoCtrl, killBusy;

  int checks = 0;
  int fails  = 0;

  // reference model state
  int   mCount, mTimer;
  logic mSw, mEng, mKill, mDir;
  logic [1:0] mFlags, mEn;

  always #2 clk = ~clk;  // 250 MHz

  ep_bank_ctrl #(.KILL_CYCLES(KILL_CYCLES)) u_ep_bank_ctrl (
    .clk(clk), .rst(rst), .dirIn(dirIn),
    .swRelease(swRelease), .swKillSet(swKillSet),
    .flagClr(flagClr), .enSet(enSet), .enClr(enClr),
    .pktInSent(pktInSent), .pktOutRcvd(pktOutRcvd),
    .busyCount(busyCount), .swBank(swBank), .engBank(engBank),
    .fifoCtrl(fifoCtrl), .killBusy(killBusy),
    .flags(flags), .enables(enables), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic expFifo();
    return mDir ? (mCount != 2) : (mCount != 0);
  endfunction

  task automatic modelReset(input logic d);
    mDir = d; mCount = 0; mTimer = 0; mSw = 0; mEng = 0;
    mKill = 0; mFlags = 0; mEn = 0;
  endtask

  task automatic modelStep(input logic rel, kil, ins, outr,
                           input logic [1:0] fclr, eset, eclr);
    logic send, recv, commit, discard, free, kstart, kend;
    int after;
    send = mDir && ins && (mCount != 0);
    after = mCount - int'(send);
    commit = 0; discard = 0; kstart = 0; kend = 0; recv = 0; free = 0;
    if (mDir) begin
      if (mKill) begin
        if (after == 0) kend = 1;
        else if (mTimer == 1) discard = 1;
      end else begin
        commit = rel && !kil && (mCount != 2);
        kstart = kil && (after != 0);
      end
    end else begin
      recv = outr && (mCount != 2);
      free = rel && (mCount != 0);
    end
    mCount = mCount + int'(commit) + int'(recv) - int'(send) - int'(discard) - int'(free);
    if (commit || discard || free) mSw = ~mSw;
    if (send || recv) mEng = ~mEng;
    if (mKill) begin
      if (kend || discard) mKill = 0;
      else mTimer = mTimer - 1;
    end else if (kstart) begin
      mKill = 1; mTimer = KILL_CYCLES;
    end
    mFlags = {recv, send} | (mFlags & ~fclr);
    mEn = eset | (mEn & ~eclr);
  endtask

  task automatic compareAll(input string tag);
    chk({tag, " count"},  int'(busyCount), mCount);
    chk({tag, " swBank"}, int'(swBank),    int'(mSw));
    chk({tag, " engBank"},int'(engBank),   int'(mEng));
    chk({tag, " flags"},  int'(flags),     int'(mFlags));
    chk({tag, " enables"},int'(enables),   int'(mEn));
    chk({tag, " irq"},    int'(irq),       int'(mFlags & mEn));
    chk({tag, " killBusy"},int'(killBusy), int'(mKill));
    chk({tag, " fifoCtrl"},int'(fifoCtrl), int'(expFifo()));
  endtask

  // One cycle: drive at a negedge, sample at the next negedge.
  task automatic step(input logic rel, kil, ins, outr,
                      input logic [1:0] fclr, eset, eclr, input string tag);
    swRelease = rel; swKillSet = kil; pktInSent = ins; pktOutRcvd = outr;
    flagClr = fclr; enSet = eset; enClr = eclr;
    modelStep(rel, kil, ins, outr, fclr, eset, eclr);
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 2'b00, 2'b00, 2'b00, tag);
  endtask

  task automatic doReset(input logic d);
    @(negedge clk);
    rst = 1; dirIn = d;
    swRelease = 0; swKillSet = 0; pktInSent = 0; pktOutRcvd = 0;
    flagClr = 0; enSet = 0; enClr = 0;
    @(negedge clk);
    @(negedge clk);
    modelReset(d);
    compareAll("R1 reset");
    rst = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0451));

    // ---------------- IN mode directed ----------------
    doReset(1'b1);
    chk("R1 count", int'(busyCount), 0);
    chk("R1 swBank", int'(swBank), 0);
    chk("R1 killBusy", int'(killBusy), 0);
    chk("R1 enables", int'(enables), 0);

    step(1, 0, 0, 0, 0, 0, 0, "R2 commit1");
    chk("R2 count", int'(busyCount), 1);
    chk("R2 swBank", int'(swBank), 1);
    chk("R2 fifoCtrl", int'(fifoCtrl), 1);
    step(1, 0, 0, 0, 0, 0, 0, "R2 commit2");
    chk("R2 fifoCtrl full", int'(fifoCtrl), 0);
    step(1, 0, 0, 0, 0, 0, 0, "R4 commit full");
    chk("R4 count", int'(busyCount), 2);
    chk("R4 swBank", int'(swBank), 0);

    step(0, 0, 1, 0, 0, 0, 0, "R3 send");
    chk("R3 count", int'(busyCount), 1);
    chk("R3 engBank", int'(engBank), 1);
    chk("R3 flag", int'(flags[0]), 1);
    step(0, 0, 0, 0, 2'b01, 0, 0, "R12 clear");
    chk("R12 cleared", int'(flags[0]), 0);
    step(0, 0, 1, 0, 2'b01, 0, 0, "R12 set wins");
    chk("R12 set wins", int'(flags[0]), 1);
    step(0, 0, 1, 0, 2'b01, 0, 0, "R3 send empty");
    chk("R3 empty count", int'(busyCount), 0);
    chk("R3 empty engBank", int'(engBank), 0);
    chk("R3 empty flag", int'(flags[0]), 0);

    // R7 plain kill, with R11 release during kill
    step(1, 0, 0, 0, 0, 0, 0, "R7 commit");
    step(0, 1, 0, 0, 0, 0, 0, "R7 kill req");
    chk("R7 killBusy up", int'(killBusy), 1);
    step(1, 0, 0, 0, 0, 0, 0, "R11 release in kill");
    chk("R11 count", int'(busyCount), 1);
    chk("R11 swBank", int'(swBank), 1);
    chk("R7 still busy", int'(killBusy), 1);
    idle("R7 done");
    chk("R7 killBusy down", int'(killBusy), 0);
    chk("R7 count", int'(busyCount), 0);
    chk("R7 swBank back", int'(swBank), 0);
    chk("R7 no tx flag", int'(flags[0]), 0);

    // R8 race during kill
    step(1, 0, 0, 0, 0, 0, 0, "R8 commit");
    step(0, 1, 0, 0, 0, 0, 0, "R8 kill req");
    step(0, 0, 1, 0, 0, 0, 0, "R8 token");
    chk("R8 count", int'(busyCount), 0);
    chk("R8 killBusy", int'(killBusy), 0);
    chk("R8 flag", int'(flags[0]), 1);
    chk("R8 swBank", int'(swBank), 1);
    // R8 race in request cycle, with R11 release alongside kill
    step(1, 0, 0, 0, 2'b01, 0, 0, "R8 commit b");
    step(1, 1, 1, 0, 0, 0, 0, "R8 same cycle");
    chk("R8 same count", int'(busyCount), 0);
    chk("R8 same killBusy", int'(killBusy), 0);
    chk("R8 same flag", int'(flags[0]), 1);
    chk("R11 same swBank", int'(swBank), 0);

    // R9 two banks
    step(1, 0, 0, 0, 2'b01, 0, 0, "R9 commit1");
    step(1, 0, 0, 0, 0, 0, 0, "R9 commit2");
    step(0, 1, 0, 0, 0, 0, 0, "R9 kill req");
    chk("R9 count busy", int'(busyCount), 2);
    step(0, 0, 1, 0, 0, 0, 0, "R9 older sent");
    chk("R9 count after send", int'(busyCount), 1);
    chk("R9 flag", int'(flags[0]), 1);
    chk("R9 still busy", int'(killBusy), 1);
    idle("R9 discard");
    chk("R9 count end", int'(busyCount), 0);
    chk("R9 killBusy end", int'(killBusy), 0);

    step(0, 1, 0, 0, 0, 0, 0, "R10 kill empty");
    chk("R10 killBusy", int'(killBusy), 0);
    chk("R10 count", int'(busyCount), 0);
    step(0, 0, 0, 1, 0, 0, 0, "R10 out in IN mode");
    chk("R10 out ignored", int'(busyCount), 0);

    step(0, 0, 0, 0, 0, 2'b01, 0, "R13 enable");
    chk("R13 irq on", int'(irq[0]), 1);
    step(0, 0, 0, 0, 0, 2'b01, 2'b01, "R13 set wins");
    chk("R13 en kept", int'(enables[0]), 1);
    step(0, 0, 0, 0, 0, 0, 2'b01, "R13 disable");
    chk("R13 irq off", int'(irq[0]), 0);
    chk("R13 flag kept", int'(flags[0]), 1);

    for (int i = 0; i < 2000; i++) begin
      step(($urandom % 3) == 0, ($urandom % 12) == 0, ($urandom % 3) == 0,
           ($urandom % 4) == 0,
           (($urandom % 4) == 0) ? 2'($urandom) : 2'b00,
           (($urandom % 6) == 0) ? 2'($urandom) : 2'b00,
           (($urandom % 6) == 0) ? 2'($urandom) : 2'b00, "MODEL in");
    end

    // ---------------- OUT mode directed ----------------
    doReset(1'b0);
    chk("R1 out fifoCtrl", int'(fifoCtrl), 0);
    step(0, 0, 0, 1, 0, 0, 0, "R5 recv");
    chk("R5 count", int'(busyCount), 1);
    chk("R5 fifoCtrl", int'(fifoCtrl), 1);
    chk("R5 flag", int'(flags[1]), 1);
    chk("R5 engBank", int'(engBank), 1);
    step(0, 0, 0, 1, 0, 0, 0, "R5 recv2");
    step(0, 0, 0, 0, 2'b10, 0, 0, "R12 clear rx");
    step(0, 0, 0, 1, 0, 0, 0, "R4 recv full");
    chk("R4 out count", int'(busyCount), 2);
    chk("R4 out flag", int'(flags[1]), 0);
    chk("R4 out engBank", int'(engBank), 0);
    step(1, 0, 0, 0, 0, 0, 0, "R6 free");
    chk("R6 count", int'(busyCount), 1);
    chk("R6 swBank", int'(swBank), 1);
    step(0, 1, 1, 0, 0, 0, 0, "R10 kill out");
    chk("R10 out killBusy", int'(killBusy), 0);
    chk("R10 out count", int'(busyCount), 1);
    chk("R10 out no tx", int'(flags[0]), 0);

    for (int i = 0; i < 2000; i++) begin
      step(($urandom % 3) == 0, ($urandom % 8) == 0, ($urandom % 4) == 0,
           ($urandom % 3) == 0,
           (($urandom % 4) == 0) ? 2'($urandom) : 2'b00,
           (($urandom % 6) == 0) ? 2'($urandom) : 2'b00,
           (($urandom % 6) == 0) ? 2'($urandom) : 2'b00, "MODEL out");
    end

    summary();
    $finish;
  end

endmodule